// File: doc/BRIEF.md
# Clock-Multiplier Settle Tracker

This block tracks when two clock multipliers are likely to have settled after software enables or reprograms them. The general channel holds a divide field, a multiply field and a settle count. The fast channel has a fixed ratio and holds only an enable bit and a settle count. A write to either channel clears that channel's lock flag and reloads its countdown. When the countdown expires, the lock flag is set.

A slow reference clock arrives as a one-cycle enable pulse in the system clock domain. The general channel counts one step on each pulse. The fast channel counts one step on every eighth pulse. A free-running prescaler, cleared only by reset, sets that rate. Each lock flag has its own mask bit, and the two masked flags are combined into a single interrupt request. The analog multipliers are not modelled. Instead the block drives an "active" output per channel, which a clock tree would use to gate the multiplier outputs.

Top module: `settle_tracker`

## Requirements
- R1: After reset the divide, multiply, halve, fast-enable and mask registers are zero. `genRun` is high only while both the stored divide value and the stored multiply value are nonzero, because a divide value of 0 holds the divided clock and the multiplier output low.
- R2: A pulse on `genWr` stores `genDivIn` and `genMulIn`. These appear on `genDivOut` and `genMulOut` on the next cycle, and `genEnabled` is high exactly when the stored multiply value is nonzero.
- R3: Any pulse on `genWr` makes `lockGen` low on the next cycle, whatever the previous state.
- R4: A write with a nonzero multiply value loads `genCountIn`. `lockGen` then rises after the slow-tick pulse that brings the count to zero, which is the max(N,1)-th slow tick after the write for a loaded value N.
- R5: Once set, a lock flag stays high until the next write to that channel, regardless of further ticks.
- R6: A pulse on `hsWr` with `hsEnIn` = 1 makes `lockHs` low on the next cycle and loads `hsCountIn`.
- R7: The fast channel counts only on slow ticks whose zero-based index since reset is 7 mod 8. `lockHs` rises after the max(N,1)-th such tick following the write.
- R8: A general write with multiply value 0, or a fast write with `hsEnIn` = 0, clears that channel's lock flag and stops its countdown. No later tick sets that flag until the channel is written again with the channel on.
- R9: A pulse on `halveWr` stores `halveIn`, and the stored value is shown on `genHalve` from the next cycle.
- R10: A pulse on `maskWr` stores `maskIn`, where bit 0 enables the general lock and bit 1 enables the fast lock. `irq` is high exactly when some lock flag is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle pulse per slow reference period |
| genWr | input | 1 | Write strobe for the general channel parameters |
| genDivIn | input | 8 | Divide value to store |
| genMulIn | input | 8 | Multiply value to store (0 turns the channel off) |
| genCountIn | input | 16 | Settle count to load |
| halveWr | input | 1 | Write strobe for the halve bit |
| halveIn | input | 1 | Halve bit value |
| hsWr | input | 1 | Write strobe for the fast channel |
| hsEnIn | input | 1 | Fast channel enable value |
| hsCountIn | input | 16 | Fast channel settle count to load |
| maskWr | input | 1 | Write strobe for the interrupt mask |
| maskIn | input | 2 | Mask value: bit 0 general, bit 1 fast |
| genDivOut | output | 8 | Stored divide value |
| genMulOut | output | 8 | Stored multiply value |
| genEnabled | output | 1 | General channel on (multiply nonzero) |
| genRun | output | 1 | Divided clock live (divide and multiply nonzero) |
| genHalve | output | 1 | Stored halve bit |
| hsEnabled | output | 1 | Stored fast-channel enable |
| lockGen | output | 1 | General channel settled |
| lockHs | output | 1 | Fast channel settled |
| irq | output | 1 | Interrupt request |

## Verification
The general channel is swept over every settle count from 0 to 6. The lock flag is sampled after each slow tick, so an off-by-one in the countdown, or a count of zero wrongly treated as a full wrap, shows up as a flag one tick early or one tick late. The fast channel is swept over counts 0 to 3 while the bench keeps its own running index of slow ticks. This separates a correct prescaler phase from one that restarts on each write or counts at the wrong rate. Other patterns check the corner cases: a reprogram in the middle of a countdown, turning a channel off after lock, a divide value of zero, and all four mask combinations. These show, in turn, whether the reload, stop, output gating and masking logic behave as specified.

// File: rtl/settle_pkg.sv
package settle_pkg;
  // Strobes issued by control into the datapath each cycle.
  typedef struct packed {
    logic genLoad;
    logic genStop;
    logic hsLoad;
    logic hsStop;
    logic genTick;
    logic hsTick;
  } strobe_t;
endpackage

// File: rtl/settle_chan.sv
module settle_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             stop,
  input  logic             tick,
  input  logic [CNT_W-1:0] initVal,
  output logic             lock
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain;
  logic             busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      busy   <= 1'b0;
      lock   <= 1'b0;
    end else if (load) begin
      remain <= initVal;
      busy   <= 1'b1;
      lock   <= 1'b0;
    end else if (stop) begin
      busy   <= 1'b0;
      lock   <= 1'b0;
    end else if (tick && busy) begin
      if (remain <= ONE) begin
        remain <= '0;
        busy   <= 1'b0;
        lock   <= 1'b1;
      end else begin
        remain <= remain - ONE;
      end
    end
  end

  AST_LOAD_CLEARS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !lock); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && tick && !load && !stop && remain > ONE) |=> (remain == $past(remain) - ONE) && busy); // R4
  AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lock) |-> $past(tick) && $past(busy)); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (lock && !load && !stop) |=> lock); // R5
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stop && !load) |=> !lock && !busy); // R8
endmodule

// File: rtl/settle_ctrl.sv
module settle_ctrl
  import settle_pkg::*;
#(
  parameter int MUL_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowTick,
  input  logic             genWr,
  input  logic [MUL_W-1:0] genMulIn,
  input  logic             hsWr,
  input  logic             hsEnIn,
  output strobe_t          stb
);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (slowTick) preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    stb.genLoad = genWr && (genMulIn != '0);
    stb.genStop = genWr && (genMulIn == '0);
    stb.hsLoad  = hsWr && hsEnIn;
    stb.hsStop  = hsWr && !hsEnIn;
    stb.genTick = slowTick;
    stb.hsTick  = slowTick && (preCnt == '1);
  end

  AST_PRE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    slowTick |=> preCnt == $past(preCnt) + PRE_W'(1)); // R7
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !slowTick |=> $stable(preCnt)); // R7
endmodule

// File: rtl/settle_dp.sv
module settle_dp
  import settle_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int MUL_W = 8,
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             genWr,
  input  logic [DIV_W-1:0] genDivIn,
  input  logic [MUL_W-1:0] genMulIn,
  input  logic [CNT_W-1:0] genCountIn,
  input  logic             halveWr,
  input  logic             halveIn,
  input  logic             hsWr,
  input  logic             hsEnIn,
  input  logic [CNT_W-1:0] hsCountIn,
  input  logic             maskWr,
  input  logic [NCH-1:0]   maskIn,
  output logic [DIV_W-1:0] divReg,
  output logic [MUL_W-1:0] mulReg,
  output logic             halveReg,
  output logic             hsEnReg,
  output logic [NCH-1:0]   lockVec,
  output logic             irqOut
);
  logic [NCH-1:0]   maskReg;
  logic [NCH-1:0]   chLoad, chStop, chTick;
  logic [CNT_W-1:0] chInit [NCH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg   <= '0;
      mulReg   <= '0;
      halveReg <= 1'b0;
      hsEnReg  <= 1'b0;
      maskReg  <= '0;
    end else begin
      if (genWr) begin
        divReg <= genDivIn;
        mulReg <= genMulIn;
      end
      if (halveWr) halveReg <= halveIn;
      if (hsWr)    hsEnReg  <= hsEnIn;
      if (maskWr)  maskReg  <= maskIn;
    end
  end

  always_comb begin
    chLoad    = '0;
    chStop    = '0;
    chTick    = '0;
    chLoad[0] = stb.genLoad;
    chStop[0] = stb.genStop;
    chTick[0] = stb.genTick;
    chLoad[1] = stb.hsLoad;
    chStop[1] = stb.hsStop;
    chTick[1] = stb.hsTick;
    for (int i = 0; i < NCH; i++) chInit[i] = '0;
    chInit[0] = genCountIn;
    chInit[1] = hsCountIn;
  end

  for (genvar g = 0; g < NCH; g++) begin : gChan
    settle_chan #(.CNT_W(CNT_W)) uChan (
      .clk     (clk),
      .rstN    (rstN),
      .load    (chLoad[g]),
      .stop    (chStop[g]),
      .tick    (chTick[g]),
      .initVal (chInit[g]),
      .lock    (lockVec[g])
    );
  end

  assign irqOut = |(lockVec & maskReg);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (maskWr && maskIn == '0) |=> !irqOut); // R10
endmodule

// File: rtl/settle_tracker.sv
module settle_tracker
  import settle_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int MUL_W = 8,
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowTick,
  input  logic             genWr,
  input  logic [DIV_W-1:0] genDivIn,
  input  logic [MUL_W-1:0] genMulIn,
  input  logic [CNT_W-1:0] genCountIn,
  input  logic             halveWr,
  input  logic             halveIn,
  input  logic             hsWr,
  input  logic             hsEnIn,
  input  logic [CNT_W-1:0] hsCountIn,
  input  logic             maskWr,
  input  logic [1:0]       maskIn,
  output logic [DIV_W-1:0] genDivOut,
  output logic [MUL_W-1:0] genMulOut,
  output logic             genEnabled,
  output logic             genRun,
  output logic             genHalve,
  output logic             hsEnabled,
  output logic             lockGen,
  output logic             lockHs,
  output logic             irq
);
  localparam int NCH = 2;

  strobe_t        stb;
  logic [NCH-1:0] lockVec;

  settle_ctrl #(.MUL_W(MUL_W), .PRE_W(PRE_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .slowTick (slowTick),
    .genWr    (genWr),
    .genMulIn (genMulIn),
    .hsWr     (hsWr),
    .hsEnIn   (hsEnIn),
    .stb      (stb)
  );

  settle_dp #(.DIV_W(DIV_W), .MUL_W(MUL_W), .CNT_W(CNT_W), .NCH(NCH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .genWr      (genWr),
    .genDivIn   (genDivIn),
    .genMulIn   (genMulIn),
    .genCountIn (genCountIn),
    .halveWr    (halveWr),
    .halveIn    (halveIn),
    .hsWr       (hsWr),
    .hsEnIn     (hsEnIn),
    .hsCountIn  (hsCountIn),
    .maskWr     (maskWr),
    .maskIn     (maskIn),
    .divReg     (genDivOut),
    .mulReg     (genMulOut),
    .halveReg   (genHalve),
    .hsEnReg    (hsEnabled),
    .lockVec    (lockVec),
    .irqOut     (irq)
  );

  assign lockGen    = lockVec[0];
  assign lockHs     = lockVec[1];
  assign genEnabled = (genMulOut != '0);
  assign genRun     = genEnabled && (genDivOut != '0);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (lockGen || lockHs)); // R10
  AST_LOCK_NEEDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    lockGen |-> genEnabled); // R8
  AST_HS_LOCK_NEEDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    lockHs |-> hsEnabled); // R8
endmodule

// File: tb/sim_settle_tracker.sv
module sim_settle_tracker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        genWr = 1'b0;
  logic [7:0]  genDivIn = '0;
  logic [7:0]  genMulIn = '0;
  logic [15:0] genCountIn = '0;
  logic        halveWr = 1'b0;
  logic        halveIn = 1'b0;
  logic        hsWr = 1'b0;
  logic        hsEnIn = 1'b0;
  logic [15:0] hsCountIn = '0;
  logic        maskWr = 1'b0;
  logic [1:0]  maskIn = '0;
  logic [7:0]  genDivOut, genMulOut;
  logic        genEnabled, genRun, genHalve, hsEnabled, lockGen, lockHs, irq;

  int nChecks = 0;
  int nFails  = 0;
  int slowSeen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  settle_tracker u0 (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .genWr(genWr), .genDivIn(genDivIn), .genMulIn(genMulIn), .genCountIn(genCountIn),
    .halveWr(halveWr), .halveIn(halveIn),
    .hsWr(hsWr), .hsEnIn(hsEnIn), .hsCountIn(hsCountIn),
    .maskWr(maskWr), .maskIn(maskIn),
    .genDivOut(genDivOut), .genMulOut(genMulOut), .genEnabled(genEnabled),
    .genRun(genRun), .genHalve(genHalve), .hsEnabled(hsEnabled),
    .lockGen(lockGen), .lockHs(lockHs), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse();
    @(negedge clk) slowTick = 1'b1;
    @(negedge clk) slowTick = 1'b0;
    slowSeen++;
  endtask

  task automatic writeGen(input int dv, input int ml, input int cn);
    @(negedge clk);
    genWr = 1'b1; genDivIn = 8'(dv); genMulIn = 8'(ml); genCountIn = 16'(cn);
    @(negedge clk) genWr = 1'b0;
  endtask

  task automatic writeHs(input bit en, input int cn);
    @(negedge clk);
    hsWr = 1'b1; hsEnIn = en; hsCountIn = 16'(cn);
    @(negedge clk) hsWr = 1'b0;
  endtask

  task automatic writeMask(input int m);
    @(negedge clk);
    maskWr = 1'b1; maskIn = 2'(m);
    @(negedge clk) maskWr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int need;
    int hsTicks;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, R10 irq quiet
    check("R1 div reset", genDivOut, 0);
    check("R1 mul reset", genMulOut, 0);
    check("R1 run reset", genRun, 0);
    check("R9 halve reset", genHalve, 0);
    check("R10 irq reset", irq, 0);
    check("R6 lockHs reset", lockHs, 0);

    // R2 / R1 field storage and gating
    writeGen(5, 7, 100);
    check("R2 div stored", genDivOut, 5);
    check("R2 mul stored", genMulOut, 7);
    check("R2 enabled", genEnabled, 1);
    check("R1 run live", genRun, 1);
    writeGen(0, 7, 100);
    check("R1 div zero gates run", genRun, 0);
    check("R2 enabled with div 0", genEnabled, 1);

    // R4 / R5 / R3 sweep of general counts
    for (int n = 0; n <= 6; n++) begin
      writeGen(2, 3, n);
      check("R3 lock cleared by write", lockGen, 0);
      need = (n < 1) ? 1 : n;
      for (int k = 1; k <= 8; k++) begin
        pulse();
        check($sformatf("R4 n=%0d k=%0d", n, k), lockGen, (k >= need) ? 1 : 0);
      end
      check("R5 lock held", lockGen, 1);
    end

    // R4 reprogram mid-count reloads
    writeGen(2, 3, 4);
    pulse(); pulse();
    writeGen(3, 9, 3);
    check("R3 reprogram clears", lockGen, 0);
    for (int k = 1; k <= 4; k++) begin
      pulse();
      check($sformatf("R4 reload k=%0d", k), lockGen, (k >= 3) ? 1 : 0);
    end

    // R8 mul = 0 stops
    writeGen(2, 0, 1);
    check("R8 off clears lock", lockGen, 0);
    check("R2 disabled", genEnabled, 0);
    for (int k = 0; k < 4; k++) pulse();
    check("R8 stays unlocked", lockGen, 0);

    // R9 halve bit
    @(negedge clk); halveWr = 1'b1; halveIn = 1'b1;
    @(negedge clk); halveWr = 1'b0; halveIn = 1'b0;
    check("R9 halve set", genHalve, 1);
    @(negedge clk); check("R9 halve kept", genHalve, 1);

    // R6 / R7 fast channel sweep using independent tick index
    for (int n = 0; n <= 3; n++) begin
      writeHs(1'b1, n);
      check("R6 hs lock cleared", lockHs, 0);
      check("R6 hs enabled", hsEnabled, 1);
      need = (n < 1) ? 1 : n;
      hsTicks = 0;
      for (int k = 0; k < 8 * (need + 1); k++) begin
        if ((slowSeen % 8) == 7) hsTicks++;
        pulse();
        check($sformatf("R7 n=%0d idx=%0d", n, slowSeen - 1), lockHs, (hsTicks >= need) ? 1 : 0);
      end
    end

    // R8 hs disable
    writeHs(1'b0, 0);
    check("R8 hs off clears", lockHs, 0);
    for (int k = 0; k < 16; k++) pulse();
    check("R8 hs stays unlocked", lockHs, 0);

    // R10 mask combos: gen locked, hs locked
    writeGen(1, 1, 0); pulse();
    writeHs(1'b1, 0);
    for (int k = 0; k < 8; k++) pulse();
    check("R10 setup gen", lockGen, 1);
    check("R10 setup hs", lockHs, 1);
    for (int m = 0; m < 4; m++) begin
      writeMask(m);
      check($sformatf("R10 mask=%0d", m), irq, (m != 0) ? 1 : 0);
    end
    writeMask(1);
    writeGen(1, 1, 5);
    check("R10 irq drops with gen lock", irq, 0);
    writeMask(2);
    check("R10 hs only", irq, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule